// File: doc/BRIEF.md
# Register-Array LIFO with Full and Empty Flags

This block is a last-in first-out store held in a small on-chip register array. A stack pointer names the topmost occupied slot and moves toward lower slot numbers as data is added. A push strobe lowers the pointer by one and then writes the input word into the slot it now names. A pop strobe copies the word at the pointer into a registered output and then raises the pointer by one.

With the default depth of eleven, the slots are numbered 0 to 10. A pointer value of 11 (the depth) means that nothing is stored. The full flag is set when the pointer reaches 0. The empty flag is set when the pointer climbs back to the depth value. A push while full or a pop while empty changes nothing and raises a single-cycle error pulse. A push and a pop in the same cycle cancel to a no-op. All results are registered, so a strobe sampled at one rising edge is visible on every output after that same edge.

Top module: `reg_lifo`

## Requirements
- R1: While reset is high and after it, until the first strobe, the pointer equals the depth (11), empty is 1, full is 0, the error output is 0 and the data output is 0.
- R2: An accepted push (push high, pop low, full low) lowers the pointer by one, stores the input word at the lowered pointer value and clears empty, all visible after the same edge.
- R3: Full is 1 exactly when the pointer is 0, which happens after the depth's worth of accepted pushes from empty.
- R4: An accepted pop (pop high, push low, empty low) loads the word stored at the current pointer into the data output, raises the pointer by one and clears full.
- R5: Empty is 1 exactly when the pointer equals the depth; the final pop of a stored word sets it again.
- R6: Pops return words in the reverse of the order in which they were pushed, including across interleaved pushes and pops.
- R7: A push while full leaves the pointer, the flags and the stored words unchanged, and the error output is 1 for exactly the following cycle.
- R8: A pop while empty leaves the pointer, the flags and the data output unchanged, and the error output is 1 for exactly the following cycle.
- R9: Push and pop high in the same cycle change neither the pointer, the flags nor the data output, and raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Request to add `din` on top of the stack |
| pop_req | input | 1 | Request to remove the top word into `dout` |
| din | input | WIDTH (16) | Word to be pushed |
| dout | output | WIDTH (16) | Last word popped, held until the next accepted pop |
| sp | output | PTR_W (4) | Stack pointer; the depth value means empty |
| full | output | 1 | High when the pointer is 0 |
| empty | output | 1 | High when the pointer equals the depth |
| err | output | 1 | One-cycle pulse after a rejected push or pop |

## Verification
Every output of this block is one register stage from its inputs. A strobe presented before a rising edge therefore shows its pointer, flag, data and error results right after that edge, and the error pulse is gone after the next one. The bench drives strobes on falling edges and compares all outputs at the following falling edge, one full cycle after stimulus. For the error pulse it takes one extra idle cycle and checks that the pulse has dropped. The tests for rejected pushes confirm that the stored words are untouched by popping the whole stack afterwards and comparing each word.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    localparam int unsigned LIFO_DEPTH = 11;
    localparam int unsigned LIFO_WIDTH = 16;

    // What a cycle's strobes resolve to once the flags are considered
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_PUSH   = 2'd1,
        OP_POP    = 2'd2,
        OP_REJECT = 2'd3
    } lifo_op_t;

    function automatic lifo_op_t classify(input logic push,
                                          input logic pop,
                                          input logic is_full,
                                          input logic is_empty);
        lifo_op_t op;
        op = OP_IDLE;
        if (push && !pop) begin
            op = is_full ? OP_REJECT : OP_PUSH;
        end else if (pop && !push) begin
            op = is_empty ? OP_REJECT : OP_POP;
        end
        return op;
    endfunction

endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
    import lifo_pkg::*;
#(
    parameter int unsigned DEPTH = LIFO_DEPTH,
    parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    output logic [PTR_W-1:0] sp,
    output logic             full,
    output logic             empty,
    output logic             err,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic             rd_en,
    output logic [PTR_W-1:0] rd_addr
);

    localparam logic [PTR_W-1:0] SP_EMPTY = PTR_W'(DEPTH);

    lifo_op_t         op;
    logic [PTR_W-1:0] sp_dn;
    logic [PTR_W-1:0] sp_up;

    always_comb begin
        op      = classify(push_req, pop_req, full, empty);
        sp_dn   = sp - PTR_W'(1);
        sp_up   = sp + PTR_W'(1);
        wr_en   = (op == OP_PUSH);
        wr_addr = sp_dn;
        rd_en   = (op == OP_POP);
        rd_addr = sp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp    <= SP_EMPTY;
            full  <= 1'b0;
            empty <= 1'b1;
            err   <= 1'b0;
        end else begin
            err <= (op == OP_REJECT);
            unique case (op)
                OP_PUSH: begin
                    sp    <= sp_dn;
                    full  <= (sp_dn == '0);
                    empty <= 1'b0;
                end
                OP_POP: begin
                    sp    <= sp_up;
                    empty <= (sp_up == SP_EMPTY);
                    full  <= 1'b0;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/lifo_regfile.sv
module lifo_regfile #(
    parameter int unsigned DEPTH = 11,
    parameter int unsigned WIDTH = 16,
    parameter int unsigned PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] slot [DEPTH];
    logic [DEPTH-1:0] hit;

    // one write-select line per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign hit[g] = wr_en && (wr_addr == PTR_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                slot[i] <= '0;
            end else if (hit[i]) begin
                slot[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr == PTR_W'(i)) begin
                rd_data = slot[i];
            end
        end
    end

endmodule

// File: rtl/reg_lifo.sv
module reg_lifo
    import lifo_pkg::*;
#(
    parameter int unsigned DEPTH = LIFO_DEPTH,
    parameter int unsigned WIDTH = LIFO_WIDTH,
    parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [PTR_W-1:0] sp,
    output logic             full,
    output logic             empty,
    output logic             err
);

    logic             wr_en;
    logic             rd_en;
    logic [PTR_W-1:0] wr_addr;
    logic [PTR_W-1:0] rd_addr;
    logic [WIDTH-1:0] rd_data;

    lifo_ctrl #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_req),
        .pop_req  (pop_req),
        .sp       (sp),
        .full     (full),
        .empty    (empty),
        .err      (err),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr)
    );

    lifo_regfile #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .PTR_W (PTR_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (rd_en) begin
            dout <= rd_data;
        end
    end

endmodule

// File: rtl/lifo_chk.sv
module lifo_chk #(
    parameter int unsigned DEPTH = 11,
    parameter int unsigned WIDTH = 16,
    parameter int unsigned PTR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             push_req,
    input logic             pop_req,
    input logic [WIDTH-1:0] dout,
    input logic [PTR_W-1:0] sp,
    input logic             full,
    input logic             empty,
    input logic             err
);

    localparam logic [PTR_W-1:0] SP_EMPTY = PTR_W'(DEPTH);

    // R2
    push_moves_down_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && !full) |=> (sp == $past(sp) - PTR_W'(1)) && !empty);

    // R3
    full_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        full == (sp == '0));

    // R4
    pop_moves_up_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && !empty) |=> (sp == $past(sp) + PTR_W'(1)) && !full);

    // R5
    empty_at_top_chk: assert property (@(posedge clk) disable iff (rst)
        empty == (sp == SP_EMPTY));

    // R7
    push_full_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && full) |=> err && $stable(sp) && full);

    // R8
    pop_empty_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && empty) |=> err && $stable(sp) && $stable(dout));

    // R9
    both_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req) |=> !err && $stable(sp) && $stable(dout));

    // R7 R8
    err_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(push_req) != $past(pop_req));

    // R3 R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

endmodule

bind reg_lifo lifo_chk #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH),
    .PTR_W (PTR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .push_req (push_req),
    .pop_req  (pop_req),
    .dout     (dout),
    .sp       (sp),
    .full     (full),
    .empty    (empty),
    .err      (err)
);

// File: tb/reg_lifo_test.sv
`timescale 1ns/1ps
module reg_lifo_test;

    localparam int DEPTH = 11;
    localparam int WIDTH = 16;
    localparam int PTR_W = 4;
    localparam int NVEC  = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push_req = 1'b0;
    logic             pop_req = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic [PTR_W-1:0] sp;
    logic             full;
    logic             empty;
    logic             err;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    reg_lifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) uut (
        .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
        .din(din), .dout(dout), .sp(sp), .full(full), .empty(empty), .err(err)
    );

    // {push, pop, din, exp_sp, exp_full, exp_empty, exp_err, exp_dout, req}
    localparam logic [44:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 16'h1111, 4'd10, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd2}, // R2
        {1'b1, 1'b0, 16'h2222, 4'd9,  1'b0, 1'b0, 1'b0, 16'h0000, 4'd2}, // R2
        {1'b1, 1'b1, 16'h3333, 4'd9,  1'b0, 1'b0, 1'b0, 16'h0000, 4'd9}, // R9
        {1'b0, 1'b1, 16'h0000, 4'd10, 1'b0, 1'b0, 1'b0, 16'h2222, 4'd4}, // R4
        {1'b1, 1'b0, 16'h4444, 4'd9,  1'b0, 1'b0, 1'b0, 16'h2222, 4'd2}, // R2
        {1'b0, 1'b1, 16'h0000, 4'd10, 1'b0, 1'b0, 1'b0, 16'h4444, 4'd6}, // R6
        {1'b0, 1'b1, 16'h0000, 4'd11, 1'b0, 1'b1, 1'b0, 16'h1111, 4'd5}, // R5
        {1'b0, 1'b1, 16'h0000, 4'd11, 1'b0, 1'b1, 1'b1, 16'h1111, 4'd8}, // R8
        {1'b0, 1'b0, 16'h0000, 4'd11, 1'b0, 1'b1, 1'b0, 16'h1111, 4'd8}, // R8
        {1'b1, 1'b0, 16'h5555, 4'd10, 1'b0, 1'b0, 1'b0, 16'h1111, 4'd2}, // R2
        {1'b0, 1'b1, 16'h0000, 4'd11, 1'b0, 1'b1, 1'b0, 16'h5555, 4'd6}  // R6
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic p, input logic q, input logic [WIDTH-1:0] d);
        push_req = p;
        pop_req  = q;
        din      = d;
        @(negedge clk);
        push_req = 1'b0;
        pop_req  = 1'b0;
    endtask

    task automatic chk_state(input string req, input int esp, input logic ef,
                             input logic ee, input logic eerr);
        chk({req, " sp"},    32'(sp),    32'(esp));
        chk({req, " full"},  32'(full),  32'(ef));
        chk({req, " empty"}, 32'(empty), 32'(ee));
        chk({req, " err"},   32'(err),   32'(eerr));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: state during and after reset
        repeat (3) @(negedge clk);
        chk_state("R1 in-reset", DEPTH, 1'b0, 1'b1, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk_state("R1 post-reset", DEPTH, 1'b0, 1'b1, 1'b0);
        chk("R1 dout", 32'(dout), 32'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [44:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[3:0], i);
            cyc(v[44], v[43], v[42:27]);
            chk_state(tag, int'(v[26:23]), v[22], v[21], v[20]);
            chk({tag, " dout"}, 32'(dout), 32'(v[19:4]));
        end

        // R3: fill to the top, full appears only at the last push
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1'b1, 1'b0, 16'hA000 + 16'(i));
            chk("R3 full flag", 32'(full), 32'(i == DEPTH - 1));
        end
        chk_state("R3 filled", 0, 1'b1, 1'b0, 1'b0);

        // R7: push while full is rejected, pulse lasts one cycle
        cyc(1'b1, 1'b0, 16'hDEAD);
        chk_state("R7 rejected", 0, 1'b1, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, '0);
        chk_state("R7 pulse end", 0, 1'b1, 1'b0, 1'b0);

        // R9 while full: both strobes change nothing
        cyc(1'b1, 1'b1, 16'hBEEF);
        chk_state("R9 full both", 0, 1'b1, 1'b0, 1'b0);

        // R4 R6 R5: drain, last-in first-out, untouched by the rejected push
        for (int i = DEPTH - 1; i >= 0; i--) begin
            cyc(1'b0, 1'b1, '0);
            chk("R6 drain order", 32'(dout), 32'(16'hA000 + 16'(i)));
            chk("R4 full cleared", 32'(full), 32'h0);
            chk("R5 empty flag", 32'(empty), 32'(i == 0));
        end
        chk_state("R5 drained", DEPTH, 1'b0, 1'b1, 1'b0);

        // R8: pop while empty keeps dout
        cyc(1'b0, 1'b1, '0);
        chk("R8 dout held", 32'(dout), 32'hA000);
        chk_state("R8 rejected", DEPTH, 1'b0, 1'b1, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule